// File: doc/BRIEF.md
# Flash Completion Poller

This controller sits on the host side of a parallel flash bus. It decides when an embedded program or erase inside the flash has finished. Software or a command sequencer first writes the command cycles that start the operation. Once the last write cycle has ended, it pulses `start` with the address being worked on, the expected byte and two flags. One flag chooses between status-bit polling and toggle polling. The other says whether the operation is a program or an erase.

While polling, the block issues back-to-back read requests on a simple request/acknowledge bus and judges each returned byte.

- **Status-bit polling:** the top status bit is compared with the value it should show on completion.
- **Toggle polling:** the toggle bit of each read is compared with that of the previous read.

The first read that indicates completion can still carry stale values in its other bits. For that reason the block then issues one confirming read and reports that byte as the result. In program mode it also flags a byte that differs from the expected one. A parameterised ceiling on the number of polling reads turns a stuck operation into a time-out.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, and whenever `rst_n` is sampled low (even in the middle of polling), `busy`, `rd_req`, `done`, `timeout` and `mismatch` are 0 and `result` is 8'h00.
- R2: A `start` sampled while idle latches `tgt_addr`, `exp_byte`, `toggle_mode` and `erase_op`, and `busy` is 1 from the next cycle. Every read of that operation carries the latched address on `rd_addr`. A `start` sampled while `busy` is 1 is ignored.
- R3: A read completes in a cycle where `rd_req` and `rd_ack` are both 1, and `rd_data` is sampled in that cycle. `rd_req` is 1 only while `busy` is 1, and the count of completed reads is exactly as R7 and R9 state.
- R4: With `toggle_mode`=0 and `erase_op`=0, a polling read indicates completion when `rd_data[7]` equals `exp_byte[7]`.
- R5: With `toggle_mode`=0 and `erase_op`=1, a polling read indicates completion when `rd_data[7]` is 1.
- R6: With `toggle_mode`=1, each polling read's `rd_data[6]` is compared with that of the previous polling read of the same operation. If they are equal, completion is indicated; if they differ, polling continues. The first polling read never indicates completion.
- R7: After the polling read that indicates completion, exactly one more read is made. Its full byte appears on `result`, and `done` is 1 for exactly one cycle, in the cycle after that read, with `busy` already 0. No further read follows, and `result` holds until the next confirming read.
- R8: `mismatch` is cleared by an accepted `start`. It is set with `done` when `erase_op`=0 and the confirming byte differs from `exp_byte`. It stays 0 for erases.
- R9: If `MAX_READS` polling reads pass without completion, `timeout` is 1 for one cycle after the last of them, no confirming read is made and the block returns to idle. Completion on the `MAX_READS`-th polling read still ends with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin polling; pulse after the last command write cycle |
| toggle_mode | input | 1 | 1: toggle polling on bit 6; 0: status-bit polling on bit 7 |
| erase_op | input | 1 | 1: erase operation; 0: program operation |
| tgt_addr | input | AW | Address inside the sector being worked on |
| exp_byte | input | 8 | Byte that was programmed |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Address of the requested read |
| rd_ack | input | 1 | Read data valid this cycle |
| rd_data | input | 8 | Returned byte |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle pulse: operation finished, `result` valid |
| timeout | output | 1 | One-cycle pulse: read ceiling reached |
| result | output | 8 | Byte from the confirming read |
| mismatch | output | 1 | Program result differs from `exp_byte` |

## Verification
The assertions rely on several properties of the inputs:
- `rd_ack` arrives only while a request is pending.
- `tgt_addr` points inside the sector under work and outside any protected sector, so that the status bits are meaningful.
- `start` is pulsed only once the command writes have completed.

The bench's bus model acknowledges only while `rd_req` is high, with per-test gaps between reads. It answers from a scripted status sequence that follows the flash's busy/complete pattern and includes a stale completion byte. It also records the address of every completed read, so the whole stimulus stays inside those assumptions. One directed test deliberately pulses `start` with altered inputs during polling, to show that it is ignored.

// File: rtl/fpoll_pkg.sv
// Shared definitions for the flash completion poller.
// Assumes: nothing beyond IEEE 1800-2017.
package fpoll_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_POLL = 2'd1,
        PS_CONF = 2'd2
    } poll_state_t;
endpackage

// File: rtl/fpoll_judge.sv
// Completion judge: decides from one returned byte whether the embedded
// operation reports completion, in status-bit or toggle mode.
// Assumes: mode inputs are held stable for the whole operation; 'clear'
// pulses once when an operation is accepted; 'sample' marks polling reads.
module fpoll_judge (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    input  logic toggle_mode,
    input  logic erase_op,
    input  logic exp_msb,
    input  logic bit7,
    input  logic bit6,
    output logic complete
);
    logic prev6;
    logic have_prev;

    // Remember bit 6 of the last polling read for toggle comparison.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            prev6     <= 1'b0;
            have_prev <= 1'b0;
        end else if (sample) begin
            prev6     <= bit6;
            have_prev <= 1'b1;
        end
    end

    // Judge the current byte against the mode's completion rule.
    always_comb begin
        if (toggle_mode) begin
            complete = have_prev && (bit6 == prev6);
        end else begin
            complete = (bit7 == (erase_op ? 1'b1 : exp_msb));
        end
    end

    // R6: in toggle mode a lone first read never counts as completion.
    p_toggle_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && toggle_mode && !have_prev) |-> !complete);
endmodule

// File: rtl/fpoll_limit.sv
// Polling read limiter: counts polling reads of one operation and flags
// the read that reaches the configured ceiling.
// Assumes: 'clear' pulses at operation start; MAX_READS >= 1.
module fpoll_limit #(
    parameter int MAX_READS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = $clog2(MAX_READS + 1);

    logic [CW-1:0] cnt;

    // Count completed polling reads, saturating at the last allowed one.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (inc && !at_limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Flag the read that would be the last one permitted.
    assign at_limit = (cnt == CW'(MAX_READS - 1));

    // R9: the count never passes the ceiling.
    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(MAX_READS));
endmodule

// File: rtl/flash_done_poller.sv
// Flash completion poller: after an embedded program or erase has been
// started, issues read cycles at one address, judges the status bits,
// makes one confirming read and reports done, mismatch or time-out.
// Assumes: 'start' arrives after the final command write; tgt_addr lies in
// the sector under work and outside protected sectors; rd_ack is only
// raised while rd_req is high.
module flash_done_poller
    import fpoll_pkg::*;
#(
    parameter int AW        = 19,
    parameter int MAX_READS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              toggle_mode,
    input  logic              erase_op,
    input  logic [AW-1:0]     tgt_addr,
    input  logic [BYTE_W-1:0] exp_byte,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    input  logic              rd_ack,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic [BYTE_W-1:0] result,
    output logic              mismatch
);
    poll_state_t       state;
    logic [AW-1:0]     addr_q;
    logic [BYTE_W-1:0] exp_q;
    logic              tog_q;
    logic              ers_q;
    logic              accept;
    logic              fire;
    logic              poll_fire;
    logic              complete;
    logic              at_limit;

    // Handshake decode for the current cycle.
    always_comb begin
        accept    = (state == PS_IDLE) && start;
        fire      = rd_req && rd_ack;
        poll_fire = fire && (state == PS_POLL);
    end

    assign busy    = (state != PS_IDLE);
    assign rd_req  = busy;
    assign rd_addr = addr_q;

    fpoll_judge u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (accept),
        .sample      (poll_fire),
        .toggle_mode (tog_q),
        .erase_op    (ers_q),
        .exp_msb     (exp_q[BYTE_W-1]),
        .bit7        (rd_data[7]),
        .bit6        (rd_data[6]),
        .complete    (complete)
    );

    fpoll_limit #(.MAX_READS(MAX_READS)) u_limit (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .inc      (poll_fire),
        .at_limit (at_limit)
    );

    // Sequence polling, confirming read and the reporting pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PS_IDLE;
            addr_q   <= '0;
            exp_q    <= '0;
            tog_q    <= 1'b0;
            ers_q    <= 1'b0;
            done     <= 1'b0;
            timeout  <= 1'b0;
            result   <= '0;
            mismatch <= 1'b0;
        end else begin
            done    <= 1'b0;
            timeout <= 1'b0;
            case (state)
                PS_IDLE: begin
                    if (start) begin
                        addr_q   <= tgt_addr;
                        exp_q    <= exp_byte;
                        tog_q    <= toggle_mode;
                        ers_q    <= erase_op;
                        mismatch <= 1'b0;
                        state    <= PS_POLL;
                    end
                end
                PS_POLL: begin
                    if (fire) begin
                        if (complete) begin
                            state <= PS_CONF;
                        end else if (at_limit) begin
                            timeout <= 1'b1;
                            state   <= PS_IDLE;
                        end
                    end
                end
                PS_CONF: begin
                    if (fire) begin
                        result   <= rd_data;
                        mismatch <= !ers_q && (rd_data != exp_q);
                        done     <= 1'b1;
                        state    <= PS_IDLE;
                    end
                end
                default: state <= PS_IDLE;
            endcase
        end
    end

    // R2: the read address does not move during an operation.
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rd_addr));

    // R2: an operation only begins from a start request.
    p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R7: done follows a completed read.
    p_done_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rd_req && rd_ack));

    // R9: the two end reports never coincide.
    p_end_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));

    // R8: mismatch is only ever reported for a program.
    p_mismatch_prog_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |-> !ers_q);
endmodule

// File: tb/flash_done_poller_test.sv
`timescale 1ns/100ps
module flash_done_poller_test;
    localparam int AW  = 19;
    localparam int MAX = 6;

    typedef struct packed {
        logic       tog;
        logic       ers;
        logic [7:0] exp;
        logic [3:0] nb;
        logic [7:0] fin;
    } vec_t;

    // tog, ers, expected byte, busy reads before completion, final byte
    localparam vec_t VECS [10] = '{
        '{1'b0, 1'b0, 8'hA5, 4'd0, 8'hA5},
        '{1'b0, 1'b0, 8'h3C, 4'd3, 8'h3C},
        '{1'b0, 1'b0, 8'h81, 4'd2, 8'h80},
        '{1'b0, 1'b1, 8'h00, 4'd4, 8'hFF},
        '{1'b1, 1'b0, 8'h5A, 4'd1, 8'h5A},
        '{1'b1, 1'b1, 8'h00, 4'd3, 8'hFF},
        '{1'b0, 1'b0, 8'hC3, 4'd5, 8'hC3},
        '{1'b0, 1'b0, 8'h77, 4'd6, 8'h77},
        '{1'b1, 1'b0, 8'h12, 4'd5, 8'h13},
        '{1'b1, 1'b1, 8'h00, 4'd6, 8'hFF}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          toggle_mode = 1'b0;
    logic          erase_op = 1'b0;
    logic [AW-1:0] tgt_addr = '0;
    logic [7:0]    exp_byte = 8'h00;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [7:0]    rd_data = 8'h00;
    logic          busy, done, timeout, mismatch;
    logic [7:0]    result;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    // bus model state
    vec_t          cur = '0;
    logic [AW-1:0] cur_addr = '0;
    int            gap_sel = 0;
    int            gctr = 0;
    int            rd_cnt = 0;
    int            addr_err = 0;
    bit            fire = 0;

    always #2.5 clk = ~clk;

    flash_done_poller #(.AW(AW), .MAX_READS(MAX)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .toggle_mode(toggle_mode),
        .erase_op(erase_op), .tgt_addr(tgt_addr), .exp_byte(exp_byte),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .busy(busy), .done(done), .timeout(timeout), .result(result),
        .mismatch(mismatch)
    );

    // Flash status byte returned for read k of the scripted sequence.
    function automatic logic [7:0] resp(vec_t v, int k);
        logic tgt;
        tgt = v.ers ? 1'b1 : v.exp[7];
        if (!v.tog) begin
            if (k < int'(v.nb))       return {~tgt, 7'(k * 13)};
            else if (k == int'(v.nb)) return {tgt, ~v.fin[6:0]};
            else                      return v.fin;
        end else begin
            if (k < int'(v.nb))       return {1'b0, k[0], 6'(k * 5)};
            else if (k == int'(v.nb)) return {1'b1, ~v.nb[0], 6'h2A};
            else                      return v.fin;
        end
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Bus model: counts reads at the edge, drives ack/data between edges.
    initial begin
        forever begin
            @(posedge clk);
            if (fire) begin
                rd_cnt++;
                gctr = gap_sel;
            end else if (gctr > 0) begin
                gctr--;
            end
            @(negedge clk);
            rd_ack  = rd_req && (gctr == 0);
            rd_data = resp(cur, rd_cnt);
            fire    = rd_req && rd_ack;
            if (fire && rd_addr != cur_addr) addr_err++;
        end
    end

    task automatic run_vec(input vec_t v, input int gap, input logic [AW-1:0] addr, input bit poke);
        bit   to_exp;
        bit   mm_exp;
        int   reads_exp;
        int   reads_seen;
        logic [7:0] res_seen;
        string tag;
        to_exp    = (int'(v.nb) + 1) > MAX;
        mm_exp    = !v.ers && (v.fin != v.exp);
        reads_exp = to_exp ? MAX : int'(v.nb) + 2;
        tag       = v.tog ? "R6" : (v.ers ? "R5" : "R4");
        @(negedge clk);
        cur = v; cur_addr = addr; gap_sel = gap; rd_cnt = 0; gctr = 0; addr_err = 0;
        start = 1'b1; toggle_mode = v.tog; erase_op = v.ers; exp_byte = v.exp; tgt_addr = addr;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", busy, 1);
        chk(mismatch == 1'b0, "R8", mismatch, 0);
        if (poke) begin
            @(negedge clk);
            start = 1'b1; tgt_addr = ~addr; erase_op = ~v.ers;
            toggle_mode = ~v.tog; exp_byte = ~v.exp;
            @(negedge clk);
            start = 1'b0;
        end
        for (int c = 0; c < 400; c++) begin
            if (done || timeout) break;
            @(negedge clk);
        end
        chk(done == !to_exp, tag, done, !to_exp);
        chk(timeout == to_exp, "R9", timeout, to_exp);
        if (!to_exp) chk(result == v.fin, "R7", result, v.fin);
        chk(mismatch == mm_exp, "R8", mismatch, mm_exp);
        chk(rd_cnt == reads_exp, to_exp ? "R9" : "R3", rd_cnt, reads_exp);
        chk(addr_err == 0, "R2", addr_err, 0);
        chk(busy == 1'b0, "R7", busy, 0);
        reads_seen = rd_cnt;
        res_seen   = result;
        @(negedge clk);
        chk(!done && !timeout, "R7", {done, timeout}, 0);
        repeat (3) @(negedge clk);
        chk(rd_cnt == reads_seen && result == res_seen, "R7", rd_cnt, reads_seen);
        chk(rd_req == 1'b0, "R3", rd_req, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !rd_req && !done && !timeout && !mismatch, "R1",
            {busy, rd_req, done, timeout, mismatch}, 0);
        chk(result == 8'h00, "R1", result, 0);

        // Table of vectors walked in one loop.
        for (int i = 0; i < 10; i++) begin
            run_vec(VECS[i], i % 3, AW'(32'h1000 + i * 7), 1'b0);
        end

        // R2: start while busy is ignored.
        run_vec('{1'b0, 1'b0, 8'h6E, 4'd3, 8'h6E}, 2, AW'(32'h2ABCD), 1'b1);

        // R1: reset in the middle of polling.
        @(negedge clk);
        cur = '{1'b0, 1'b0, 8'h44, 4'd5, 8'h44}; cur_addr = AW'(32'h300);
        gap_sel = 1; rd_cnt = 0; gctr = 0;
        start = 1'b1; toggle_mode = 1'b0; erase_op = 1'b0; exp_byte = 8'h44; tgt_addr = AW'(32'h300);
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !rd_req && !done && !timeout && !mismatch, "R1",
            {busy, rd_req, done, timeout, mismatch}, 0);
        chk(result == 8'h00, "R1", result, 0);
        rst_n = 1'b1;

        // Normal operation after the reset.
        run_vec('{1'b1, 1'b0, 8'h99, 4'd2, 8'h99}, 0, AW'(32'h7FFFF), 1'b0);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule